// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block moves and scans runs of bytes over a single byte-wide memory port. It holds a 16-bit source pointer, a 16-bit destination pointer and a 16-bit byte counter. On a start pulse it either copies bytes from the source to the destination or compares source bytes against an 8-bit match value. Each operation runs once or repeats. The pointers step up or down by one after each byte. After every byte step the block updates a zero flag and a counter-exhausted flag.

A repeating operation can be paused between byte steps by a pending-interrupt input. When paused, the block drops back to idle with its registers intact and raises a resume indication. The next start pulse then continues from the saved pointers and count and does not load new initial values. The memory port has a one-cycle read latency. A copy step takes three cycles: read, capture, write. A search step takes two cycles: read, compare.

Top module: `blkeng`

## Requirements
- R1: A copy step asserts `mem_rd` at the source address. In the next cycle it captures `mem_rdata`, which is valid one cycle after `mem_rd`. In the cycle after that it asserts `mem_wr` at the destination address with the captured byte. It then steps both pointers and lowers the counter by one. `mem_rd` and `mem_wr` are never high together.
- R2: With `op_dec`=0 the pointers step by +1 after each byte; with `op_dec`=1 they step by -1.
- R3: A repeating copy (`op_repeat`=1) runs byte steps until the counter reaches zero, so an initial count N moves N bytes.
- R4: A search step reads the source byte and sets `flag_z` to 1 if it equals `match_val`, else 0. It lowers the counter by one and steps only the source pointer. It never writes memory and leaves the destination pointer unchanged.
- R5: After every byte step of either kind, `flag_pv` is 1 exactly when the counter is zero after its decrement.
- R6: A repeating search stops after the first step that finds a match, or after the step that brings the counter to zero, whichever comes first.
- R7: If `irq_pend` is high when a repeating step completes and the operation would otherwise continue, the block goes idle without a done pulse. It keeps its pointers and count and sets `resume_pending`. A later start continues from the kept state, ignores `src_init`, `dst_init` and `cnt_init`, and clears `resume_pending`.
- R8: A count of zero at the start of a repeating operation means 65536 bytes. The first decrement wraps the counter to 0xFFFF and the operation continues.
- R9: `done` is high for exactly one cycle after an operation ends normally. `busy` is high from the cycle after an accepted start until the operation ends. A start pulse while busy has no effect.
- R10: After reset the block is idle. All pointers, the counter and both flags are zero, `resume_pending` is 0, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start or resume an operation |
| op_search | input | 1 | 1 selects search, 0 selects copy |
| op_dec | input | 1 | 1 steps pointers downward |
| op_repeat | input | 1 | 1 selects the repeating form |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 16 | Initial byte count |
| match_val | input | 8 | Value that a search compares against |
| irq_pend | input | 1 | Pending interrupt; pauses a repeating operation |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resume_pending | output | 1 | Operation paused and resumable |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| byte_cnt | output | 16 | Current byte count |
| flag_z | output | 1 | Search equality flag |
| flag_pv | output | 1 | Counter-exhausted flag |

## Verification
The hardest state to reach is the wrap of a zero count in a repeating copy. Running all 65536 bytes to the end would blow the cycle budget. The bench instead holds `irq_pend` high from the start, so the block pauses after its first byte. It then checks that the counter reads 0xFFFF, that the flag is clear and that a resume is pending. The pause-and-resume path is tested as a split run: one step, then a resume with misleading initial values on the inputs. The final memory image and pointers must match an uninterrupted copy.

// File: rtl/blkeng_pkg.sv
package blkeng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2,
        ST_WR   = 2'd3
    } state_e;
endpackage

// File: rtl/blkeng_ptr_step.sv
module blkeng_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    always_comb begin
        if (down) nxt = cur - ONE;
        else      nxt = cur + ONE;
    end
endmodule

// File: rtl/blkeng_byte_cmp.sv
module blkeng_byte_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          eq
);
    always_comb eq = (a == b);
endmodule

// File: rtl/blkeng_term.sv
module blkeng_term (
    input  logic rpt,
    input  logic search,
    input  logic hit,
    input  logic cnt_zero,
    input  logic irq,
    output logic fin,
    output logic pause
);
    always_comb begin
        fin   = !rpt || cnt_zero || (search && hit);
        pause = !fin && irq;
    end
endmodule

// File: rtl/blkeng.sv
module blkeng
    import blkeng_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_search,
    input  logic          op_dec,
    input  logic          op_repeat,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    input  logic [DW-1:0] match_val,
    input  logic          irq_pend,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          resume_pending,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] byte_cnt,
    output logic          flag_z,
    output logic          flag_pv
);
    localparam int NPTR = 2;
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        state_e        state;
        logic          search;
        logic          dec;
        logic          rpt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          z;
        logic          pv;
        logic          done;
        logic          resume;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] ptr_cur  [NPTR];
    logic [AW-1:0] ptr_next [NPTR];
    logic [CW-1:0] cnt_dec;
    logic          cnt_zero;
    logic          hit;
    logic          fin;
    logic          pause;

    assign ptr_cur[0] = r_q.src;
    assign ptr_cur[1] = r_q.dst;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        blkeng_ptr_step #(.W(AW)) u_step (
            .cur  (ptr_cur[gi]),
            .down (r_q.dec),
            .nxt  (ptr_next[gi])
        );
    end

    assign cnt_dec  = r_q.cnt - CNT_ONE;
    assign cnt_zero = (cnt_dec == '0);

    blkeng_byte_cmp #(.DW(DW)) u_cmp (
        .a  (mem_rdata),
        .b  (match_val),
        .eq (hit)
    );

    blkeng_term u_term (
        .rpt      (r_q.rpt),
        .search   (r_q.search),
        .hit      (hit),
        .cnt_zero (cnt_zero),
        .irq      (irq_pend),
        .fin      (fin),
        .pause    (pause)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = r_q.src;
        mem_wdata = r_q.data;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.search = op_search;
                    r_d.dec    = op_dec;
                    r_d.rpt    = op_repeat;
                    if (!r_q.resume) begin
                        r_d.src = src_init;
                        r_d.dst = dst_init;
                        r_d.cnt = cnt_init;
                    end
                    r_d.resume = 1'b0;
                    r_d.state  = ST_RD;
                end
            end
            ST_RD: begin
                mem_rd    = 1'b1;
                mem_addr  = r_q.src;
                r_d.state = ST_CAP;
            end
            ST_CAP: begin
                if (r_q.search) begin
                    r_d.z   = hit;
                    r_d.src = ptr_next[0];
                    r_d.cnt = cnt_dec;
                    r_d.pv  = cnt_zero;
                    if (fin) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else if (pause) begin
                        r_d.state  = ST_IDLE;
                        r_d.resume = 1'b1;
                    end else begin
                        r_d.state = ST_RD;
                    end
                end else begin
                    r_d.data  = mem_rdata;
                    r_d.state = ST_WR;
                end
            end
            ST_WR: begin
                mem_wr    = 1'b1;
                mem_addr  = r_q.dst;
                mem_wdata = r_q.data;
                r_d.src   = ptr_next[0];
                r_d.dst   = ptr_next[1];
                r_d.cnt   = cnt_dec;
                r_d.pv    = cnt_zero;
                if (fin) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else if (pause) begin
                    r_d.state  = ST_IDLE;
                    r_d.resume = 1'b1;
                end else begin
                    r_d.state = ST_RD;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy           = (r_q.state != ST_IDLE);
    assign done           = r_q.done;
    assign resume_pending = r_q.resume;
    assign src_ptr        = r_q.src;
    assign dst_ptr        = r_q.dst;
    assign byte_cnt       = r_q.cnt;
    assign flag_z         = r_q.z;
    assign flag_pv        = r_q.pv;
endmodule

// File: rtl/blkeng_chk.sv
module blkeng_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          resume_pending,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          op_is_search,
    input logic [AW-1:0] dst_ptr,
    input logic [CW-1:0] byte_cnt
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (byte_cnt != $past(byte_cnt)))
        |-> (byte_cnt == $past(byte_cnt) - 1'b1)); // R1

    AST_SEARCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_is_search) |-> !mem_wr); // R4

    AST_SEARCH_DST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && op_is_search) |-> $stable(dst_ptr)); // R4

    AST_PAUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pending |-> !busy); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R10
endmodule

bind blkeng blkeng_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .resume_pending (resume_pending),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .op_is_search   (r_q.search),
    .dst_ptr        (dst_ptr),
    .byte_cnt       (byte_cnt)
);

// File: tb/blkeng_test.sv
module blkeng_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_search = 1'b0, op_dec = 1'b0, op_repeat = 1'b0;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [7:0]  match_val = '0;
    logic        irq_pend = 1'b0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, resume_pending;
    logic [15:0] src_ptr, dst_ptr, byte_cnt;
    logic        flag_z, flag_pv;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int done_hi = 0;

    logic [7:0] mem [0:4095];
    logic [7:0] ref_b [0:15];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    always @(negedge clk) if (done) done_hi++;

    blkeng uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_search(op_search), .op_dec(op_dec), .op_repeat(op_repeat),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .match_val(match_val), .irq_pend(irq_pend),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .resume_pending(resume_pending),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .byte_cnt(byte_cnt),
        .flag_z(flag_z), .flag_pv(flag_pv)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        irq_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill();
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    endtask

    task automatic launch(input logic s, input logic d, input logic r,
                          input logic [15:0] sa, input logic [15:0] da,
                          input logic [15:0] c, input logic [7:0] m);
        @(negedge clk);
        op_search = s; op_dec = d; op_repeat = r;
        src_init = sa; dst_init = da; cnt_init = c; match_val = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 busy", busy, 0);
        check("R10 regs", {src_ptr, dst_ptr}, 0);
        check("R10 cnt/flags", {byte_cnt, flag_z, flag_pv, resume_pending}, 0);
        check("R10 no access", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_copy_single();
        logic [7:0] keep;
        fill();
        keep = mem[12'h081];
        done_hi = 0;
        launch(0, 0, 0, 16'h0010, 16'h0080, 16'd3, 8'h00);
        check("R9 busy after start", busy, 1);
        wait_idle();
        check("R1 byte copied", mem[12'h080], 8'(16'h10 * 7 + 3));
        check("R1 single step only", mem[12'h081], keep);
        check("R2 inc pointers", {src_ptr, dst_ptr}, {16'h0011, 16'h0081});
        check("R1 counter", byte_cnt, 16'd2);
        check("R5 pv clear", flag_pv, 0);
        check("R9 done one cycle", done_hi, 1);
    endtask

    task automatic t_copy_repeat_inc();
        fill();
        for (int i = 0; i < 8; i++) ref_b[i] = mem[12'h020 + i];
        launch(0, 0, 1, 16'h0020, 16'h0400, 16'd8, 8'h00);
        wait_idle();
        for (int i = 0; i < 8; i++) check("R3 repeat copy byte", mem[12'h400 + i], ref_b[i]);
        check("R3 untouched after block", mem[12'h408], 8'(12'h408 * 7 + 3));
        check("R3 end regs", {src_ptr, dst_ptr, byte_cnt}, {16'h0028, 16'h0408, 16'd0});
        check("R5 pv set at zero", flag_pv, 1);
    endtask

    task automatic t_copy_repeat_dec();
        fill();
        for (int i = 0; i < 4; i++) ref_b[i] = mem[12'h02F - i];
        launch(0, 1, 1, 16'h002F, 16'h003F, 16'd4, 8'h00);
        wait_idle();
        for (int i = 0; i < 4; i++) check("R2 dec copy byte", mem[12'h03F - i], ref_b[i]);
        check("R2 dec end regs", {src_ptr, dst_ptr, byte_cnt}, {16'h002B, 16'h003B, 16'd0});
    endtask

    task automatic t_search_single();
        fill();
        mem[12'h200] = 8'h55;
        launch(1, 0, 0, 16'h0200, 16'h0777, 16'd1, 8'h55);
        wait_idle();
        check("R4 z on equal", flag_z, 1);
        check("R4 src step, dst held", {src_ptr, dst_ptr}, {16'h0201, 16'h0777});
        check("R4 no write", mem[12'h777], 8'(12'h777 * 7 + 3));
        check("R5 pv at zero", {byte_cnt, flag_pv}, {16'd0, 1'b1});
    endtask

    task automatic t_search_match();
        fill();
        for (int i = 0; i < 16; i++) mem[12'h300 + i] = 8'h00;
        mem[12'h30A] = 8'hA5;
        launch(1, 1, 1, 16'h030F, 16'h0000, 16'd10, 8'hA5);
        wait_idle();
        check("R6 stop on match src", src_ptr, 16'h0309);
        check("R6 stop on match cnt", byte_cnt, 16'd4);
        check("R6 flags", {flag_z, flag_pv}, 2'b10);
    endtask

    task automatic t_search_nomatch();
        launch(1, 0, 1, 16'h0300, 16'h0000, 16'd3, 8'hEE);
        wait_idle();
        check("R6 exhaust regs", {src_ptr, byte_cnt}, {16'h0303, 16'd0});
        check("R6 exhaust flags", {flag_z, flag_pv}, 2'b01);
    endtask

    task automatic t_interrupt();
        fill();
        for (int i = 0; i < 5; i++) ref_b[i] = mem[12'h040 + i];
        done_hi = 0;
        irq_pend = 1'b1;
        launch(0, 0, 1, 16'h0040, 16'h0500, 16'd5, 8'h00);
        wait_idle();
        irq_pend = 1'b0;
        check("R7 paused", resume_pending, 1);
        check("R7 kept regs", {src_ptr, dst_ptr, byte_cnt}, {16'h0041, 16'h0501, 16'd4});
        check("R7 no done on pause", done_hi, 0);
        launch(0, 0, 1, 16'h0900, 16'h0A00, 16'd2, 8'h00);
        wait_idle();
        for (int i = 0; i < 5; i++) check("R7 resumed copy", mem[12'h500 + i], ref_b[i]);
        check("R7 resumed end", {src_ptr, dst_ptr, byte_cnt, resume_pending}, {16'h0045, 16'h0505, 16'd0, 1'b0});
    endtask

    task automatic t_zero_count();
        fill();
        irq_pend = 1'b1;
        launch(0, 0, 1, 16'h0600, 16'h0700, 16'd0, 8'h00);
        wait_idle();
        irq_pend = 1'b0;
        check("R8 wrap count", byte_cnt, 16'hFFFF);
        check("R8 continues (paused not done)", {resume_pending, flag_pv}, 2'b10);
        do_reset();
    endtask

    task automatic t_busy_ignore();
        fill();
        for (int i = 0; i < 3; i++) ref_b[i] = mem[12'h060 + i];
        launch(0, 0, 1, 16'h0060, 16'h0800, 16'd3, 8'h00);
        launch(1, 1, 0, 16'h0111, 16'h0222, 16'd9, 8'h00);
        wait_idle();
        for (int i = 0; i < 3; i++) check("R9 start while busy ignored", mem[12'h800 + i], ref_b[i]);
        check("R9 end regs", {src_ptr, dst_ptr, byte_cnt}, {16'h0063, 16'h0803, 16'd0});
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        fill();
        do_reset();
        t_reset();
        t_copy_single();
        t_copy_repeat_inc();
        t_copy_repeat_dec();
        t_search_single();
        t_search_match();
        t_search_nomatch();
        t_interrupt();
        t_zero_count();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule